// File: doc/BRIEF.md
# Clause-22 Station Management Master with Start-up PHY Isolation

This block is the management-bus master of an Ethernet bridge. It runs from the 12 MHz system clock and produces the management clock and a tri-stated management data line, split here into an output value, an output enable and an input. A host-side port accepts one read or one write at a time. Each request carries a 5-bit PHY address, a 5-bit register number and, for writes, 16 bits of data. Read data comes back with a one-cycle done pulse.

When reset is released, the block waits for a configuration loader to present two PHY descriptor bytes. Each byte holds a 3-bit type in bits [7:5] and a 5-bit PHY address in bits [4:0]. A type of 3'b111 means no supported PHY sits in that slot. A type of 3'b100 means that PHY's link is to be treated as always up. After the loader's strobe, the block writes 16'h0C00 into control register 0 of three PHYs, in this order: PHY address 0, then the PHY in slot A, then the PHY in slot B. That value sets the isolate bit (10) and the power-down bit (11). Any slot whose type is 3'b111 is skipped. Host requests are refused until this sequence has finished.

Every frame is 32 preamble ones, then start 01, the opcode (10 read, 01 write), the PHY address, the register number, the turnaround and 16 data bits, all MSB first. The management clock is the system clock divided by 32: 16 cycles low, then 16 cycles high. Output data changes together with the falling edge of the management clock. Input data is sampled at the rising edge.

Top module: `mdio_mgmt_master`

## Requirements
- R1: While reset is asserted and just after it is released: mdc is low, mdio_oe is low, done is low and busy is high.
- R2: No frame starts before cfg_valid. After cfg_valid the block sends write frames to register 0 with data 16'h0C00, in this order: PHY 0, then the slot A address (cfg_phy_a[4:0]), then the slot B address (cfg_phy_b[4:0]).
- R3: A slot whose type field (bits [7:5]) is 3'b111 gets no start-up frame. The remaining frames keep their relative order.
- R4: busy stays high until the start-up sequence is complete. A req_valid presented while busy is high starts no frame and produces no done.
- R5: While a frame is running, mdc has a period of 32 clock cycles, with 16 low and 16 high. Whenever no frame is running, mdc is low.
- R6: While mdio_oe stays high, mdio_o changes only in the clock cycle in which mdc falls.
- R7: A write frame is 32 ones, then 01, 01, PHY[4:0], REG[4:0], 10 and DATA[15:0], all MSB first, and mdio_oe is high for all 64 bit periods.
- R8: A read frame drives 32 ones, 01, 10, PHY[4:0] and REG[4:0]. It releases mdio_oe for the two turnaround and sixteen data bit periods. It samples mdio_i at the rising edges of mdc, MSB first, and presents the 16-bit result on rd_data when done is high.
- R9: After cfg_valid, link_forced[0] is high exactly when the slot A type is 3'b100, and link_forced[1] is high exactly when the slot B type is 3'b100.
- R10: done is a single-cycle pulse after the last bit period of a host frame. busy is low in that cycle, so a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Loader strobe: descriptor bytes are valid |
| cfg_phy_a | input | 8 | Slot A descriptor: type [7:5], address [4:0] |
| cfg_phy_b | input | 8 | Slot B descriptor: type [7:5], address [4:0] |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Request refused this cycle |
| done | output | 1 | Host frame finished (one cycle) |
| rd_data | output | 16 | Data returned by the last read |
| link_forced | output | 2 | Per-slot link-always-up flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The hardest condition to reach from the ports is a host request that arrives while the start-up writes are still on the wire. Each start-up frame takes about two thousand cycles, so the stimulus raises req_valid in the middle of that window and then counts the frames on the bus, confirming that the request leaves no trace. Slot skipping needs a fresh reset with descriptor bytes marked absent. For that reason the bench resets the block several times with different slot patterns. A bench-side PHY model drives the read data on the falling edges of mdc, so the value returned on rd_data exposes any error in the sample edge or the bit order.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int          SLOTS           = 2;
  localparam logic [2:0]  TYPE_ABSENT     = 3'b111;
  localparam logic [2:0]  TYPE_LINK_UP    = 3'b100;
  localparam logic [4:0]  CTRL_REG_ADDR   = 5'd0;
  localparam logic [15:0] ISOLATE_PD_WORD = 16'h0C00;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mdio_req_t;

endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  assign rise_evt = run && (cnt_q == CW'(HALF - 1));
  assign fall_evt = run && (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else begin
      cnt_d = fall_evt ? '0 : cnt_q + 1'b1;
      if (rise_evt) mdc_d = 1'b1;
      else if (fall_evt) mdc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  mdio_req_t   req,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam int NBITS    = PRE_BITS + 32;
  localparam int IW       = $clog2(NBITS + 1);
  localparam int TA_POS   = PRE_BITS + 14;
  localparam int DATA_POS = PRE_BITS + 16;

  logic          active_q, active_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [31:0]   sh_q, sh_d;
  logic          wr_q, wr_d;
  logic [15:0]   rd_q, rd_d;
  logic          done_q, done_d;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    wr_d     = wr_q;
    rd_d     = rd_q;
    done_d   = 1'b0;
    if (!active_q) begin
      if (go) begin
        active_d = 1'b1;
        idx_d    = '0;
        wr_d     = req.wr;
        sh_d     = {2'b01, (req.wr ? 2'b01 : 2'b10), req.phy, req.regad,
                    (req.wr ? 2'b10 : 2'b00), (req.wr ? req.wdata : 16'h0000)};
      end
    end else begin
      if (rise_evt && !wr_q && (idx_q >= IW'(DATA_POS)))
        rd_d = {rd_q[14:0], mdio_i};
      if (fall_evt) begin
        if (idx_q == IW'(NBITS - 1)) begin
          active_d = 1'b0;
          done_d   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
          if (idx_q >= IW'(PRE_BITS)) sh_d = {sh_q[30:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      wr_q     <= 1'b0;
      rd_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      sh_q     <= sh_d;
      wr_q     <= wr_d;
      rd_q     <= rd_d;
      done_q   <= done_d;
    end
  end

  assign active  = active_q;
  assign mdio_o  = active_q && ((idx_q < IW'(PRE_BITS)) || sh_q[31]);
  assign mdio_oe = active_q && (wr_q || (idx_q < IW'(TA_POS)));
  assign done    = done_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/phy_startup_seq.sv
module phy_startup_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  input  logic [7:0]       cfg_a,
  input  logic [7:0]       cfg_b,
  input  logic             eng_done,
  output logic             go,
  output mdio_req_t        req,
  output logic             init_done,
  output logic [SLOTS-1:0] link_forced
);
  typedef enum logic [1:0] {S_WAIT_CFG, S_ISSUE, S_WAIT, S_DONE} seq_state_t;

  seq_state_t       st_q, st_d;
  logic [1:0]       step_q, step_d;
  logic [7:0]       cfg_q [SLOTS];
  logic [7:0]       cfg_d [SLOTS];
  logic [SLOTS-1:0] absent;
  logic             cfg_ok;
  logic             skip;
  logic [4:0]       target;

  assign cfg_ok = (st_q != S_WAIT_CFG);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign absent[g]      = (cfg_q[g][7:5] == TYPE_ABSENT);
    assign link_forced[g] = cfg_ok && (cfg_q[g][7:5] == TYPE_LINK_UP);
  end

  // step 0 addresses PHY 0, steps 1 and 2 address slots A and B
  assign skip   = (step_q != 2'd0) && absent[step_q[1]];
  assign target = (step_q == 2'd0) ? 5'd0 : cfg_q[step_q[1]][4:0];

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    cfg_d[0] = cfg_q[0];
    cfg_d[1] = cfg_q[1];
    go       = 1'b0;
    unique case (st_q)
      S_WAIT_CFG: if (cfg_valid) begin
        cfg_d[0] = cfg_a;
        cfg_d[1] = cfg_b;
        step_d   = 2'd0;
        st_d     = S_ISSUE;
      end
      S_ISSUE: begin
        if (skip) begin
          if (step_q == 2'd2) st_d = S_DONE;
          else step_d = step_q + 2'd1;
        end else begin
          go   = 1'b1;
          st_d = S_WAIT;
        end
      end
      S_WAIT: if (eng_done) begin
        if (step_q == 2'd2) st_d = S_DONE;
        else begin
          step_d = step_q + 2'd1;
          st_d   = S_ISSUE;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_WAIT_CFG;
      step_q   <= 2'd0;
      cfg_q[0] <= '0;
      cfg_q[1] <= '0;
    end else begin
      st_q     <= st_d;
      step_q   <= step_d;
      cfg_q[0] <= cfg_d[0];
      cfg_q[1] <= cfg_d[1];
    end
  end

  assign req.wr    = 1'b1;
  assign req.phy   = target;
  assign req.regad = CTRL_REG_ADDR;
  assign req.wdata = ISOLATE_PD_WORD;
  assign init_done = (st_q == S_DONE);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int MDC_DIV       = 32,
  parameter int PREAMBLE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [7:0]  cfg_phy_a,
  input  logic [7:0]  cfg_phy_b,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic [1:0]  link_forced,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       eng_active, eng_done, eng_go;
  logic       rise_evt, fall_evt;
  logic       seq_go, init_done, host_acc;
  mdio_req_t  seq_req, host_req, eng_req;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign busy     = !init_done || eng_active;
  assign host_acc = req_valid && !busy;

  assign host_req.wr    = req_write;
  assign host_req.phy   = req_phy;
  assign host_req.regad = req_reg;
  assign host_req.wdata = req_wdata;

  assign eng_go  = init_done ? host_acc : seq_go;
  assign eng_req = init_done ? host_req : seq_req;
  assign done    = eng_done && init_done;

  mdc_gen #(.DIV(MDC_DIV)) i_mdc_gen (
    .clk(clk), .rst_n(rst_int_n), .run(eng_active),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine #(.PRE_BITS(PREAMBLE_BITS)) i_engine (
    .clk(clk), .rst_n(rst_int_n), .go(eng_go), .req(eng_req),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .active(eng_active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done(eng_done), .rd_data(rd_data)
  );

  phy_startup_seq i_startup (
    .clk(clk), .rst_n(rst_int_n), .cfg_valid(cfg_valid),
    .cfg_a(cfg_phy_a), .cfg_b(cfg_phy_b), .eng_done(eng_done),
    .go(seq_go), .req(seq_req), .init_done(init_done),
    .link_forced(link_forced)
  );
endmodule

module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic eng_active,
  input logic init_done
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10

  AST_BUSY_UNTIL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> busy);  // R4

  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> !mdc);  // R5

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));  // R6

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .eng_active(eng_active),
  .init_done(init_done)
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  logic        clk;
  logic        rst_n;
  logic        cfg_valid;
  logic [7:0]  cfg_phy_a, cfg_phy_b;
  logic        req_valid, req_write;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        busy, done;
  logic [15:0] rd_data;
  logic [1:0]  link_forced;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int n_chk = 0;
  int n_fail = 0;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
    .cfg_phy_a(cfg_phy_a), .cfg_phy_b(cfg_phy_b),
    .req_valid(req_valid), .req_write(req_write), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .link_forced(link_forced), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // bench PHY model and bus monitor
  logic [63:0] fr_bits, fr_oe;
  logic [63:0] cap_bits [16];
  logic [63:0] cap_oe [16];
  int          bitn = 0;
  int          nfr = 0;
  int          mdc_bad = 0;
  int          data_bad = 0;
  time         t_rise = 0;
  logic [15:0] phy_val = 16'h0000;

  initial mdio_i = 1'b1;

  always @(posedge mdc) begin
    if (bitn > 0 && ($time - t_rise) != 640) mdc_bad++;
    t_rise  = $time;
    fr_bits = {fr_bits[62:0], mdio_o};
    fr_oe   = {fr_oe[62:0], mdio_oe};
    bitn++;
    if (bitn == 64) begin
      if (nfr < 16) begin
        cap_bits[nfr] = fr_bits;
        cap_oe[nfr]   = fr_oe;
      end
      nfr++;
      bitn = 0;
    end
  end

  always @(negedge mdc) begin
    if (($time - t_rise) != 320) mdc_bad++;
    if (bitn >= 48 && bitn <= 63) mdio_i = phy_val[63-bitn];
    else mdio_i = 1'b1;
  end

  logic p_mdc, p_o, p_oe;
  initial begin p_mdc = 1'b0; p_o = 1'b0; p_oe = 1'b0; end
  always @(negedge clk) begin
    if (mdio_oe && p_oe && (mdio_o != p_o) && !(p_mdc && !mdc)) data_bad++;
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
            (wr ? 2'b10 : 2'b00), (wr ? d : 16'h0000)};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic do_reset(input logic [7:0] a, input logic [7:0] b);
    rst_n = 1'b0; cfg_valid = 1'b0; cfg_phy_a = a; cfg_phy_b = b;
    req_valid = 1'b0; req_write = 1'b0; req_phy = '0; req_reg = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset(8'h01, 8'h02);
    // R1: idle outputs, busy held
    chk(!mdc && !mdio_oe && !done && busy, "R1",
        {mdc, mdio_oe, done, busy}, 4'b0001);
    // R2: nothing without cfg_valid
    repeat (200) @(negedge clk);
    chk(nfr == 0 && !mdio_oe, "R2", nfr, 0);
  endtask

  task automatic t_startup_full();
    int base;
    do_reset(8'h01, 8'h9F);  // slot A type 000 addr 1, slot B type 100 addr 31
    base = nfr;
    @(negedge clk); cfg_valid = 1'b1;
    @(negedge clk); cfg_valid = 1'b0;
    repeat (3000) @(negedge clk);
    chk(busy, "R4", busy, 1);
    req_valid = 1'b1; req_write = 1'b0; req_phy = 5'd5; req_reg = 5'd3;
    @(negedge clk); req_valid = 1'b0;
    wait_idle(10000);
    chk(!busy, "R4", busy, 0);
    chk(nfr - base == 3, "R2", nfr - base, 3);
    chk(cap_bits[base]   == exp_frame(1'b1, 5'd0,  5'd0, 16'h0C00), "R2",
        cap_bits[base],   exp_frame(1'b1, 5'd0,  5'd0, 16'h0C00));
    chk(cap_bits[base+1] == exp_frame(1'b1, 5'd1,  5'd0, 16'h0C00), "R2",
        cap_bits[base+1], exp_frame(1'b1, 5'd1,  5'd0, 16'h0C00));
    chk(cap_bits[base+2] == exp_frame(1'b1, 5'd31, 5'd0, 16'h0C00), "R7",
        cap_bits[base+2], exp_frame(1'b1, 5'd31, 5'd0, 16'h0C00));
    chk(cap_oe[base] == 64'hFFFF_FFFF_FFFF_FFFF, "R7", cap_oe[base], 64'hFFFF_FFFF_FFFF_FFFF);
    chk(link_forced == 2'b10, "R9", link_forced, 2'b10);
    repeat (2500) @(negedge clk);
    // R4: refused request left no frame behind
    chk(nfr - base == 3 && !mdc && !done, "R4", nfr - base, 3);
    chk(mdc_bad == 0, "R5", mdc_bad, 0);
  endtask

  task automatic host_op(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] d, output int done_cycles, output logic [15:0] rdv);
    int seen = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R10", busy, 1);
    rdv = '0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin
        seen++;
        rdv = rd_data;
        chk(!busy, "R10", busy, 0);
        @(negedge clk);
        if (done) seen++;
        break;
      end
    end
    done_cycles = seen;
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
    int base, dc;
    logic [15:0] got;
    logic [63:0] ef;
    base = nfr;
    phy_val = v;
    host_op(1'b0, phy, rg, 16'h0, dc, got);
    ef = exp_frame(1'b0, phy, rg, 16'h0);
    chk(dc == 1, "R10", dc, 1);
    chk(got == v, "R8", got, v);
    chk(cap_bits[base][63:18] == ef[63:18], "R8", cap_bits[base], ef);
    chk(cap_oe[base] == (~64'h0 << 18), "R8", cap_oe[base], ~64'h0 << 18);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    int base, dc;
    logic [15:0] got;
    base = nfr;
    host_op(1'b1, phy, rg, d, dc, got);
    chk(dc == 1, "R10", dc, 1);
    chk(cap_bits[base] == exp_frame(1'b1, phy, rg, d), "R7",
        cap_bits[base], exp_frame(1'b1, phy, rg, d));
    chk(data_bad == 0, "R6", data_bad, 0);
    chk(mdc_bad == 0 && !mdc, "R5", mdc_bad, 0);
  endtask

  task automatic t_skip(input logic [7:0] a, input logic [7:0] b, input int n_exp,
                        input logic [4:0] second_addr);
    int base;
    do_reset(a, b);
    base = nfr;
    @(negedge clk); cfg_valid = 1'b1;
    @(negedge clk); cfg_valid = 1'b0;
    wait_idle(10000);
    // R3: absent slots produce no frame
    chk(nfr - base == n_exp, "R3", nfr - base, n_exp);
    chk(cap_bits[base] == exp_frame(1'b1, 5'd0, 5'd0, 16'h0C00), "R3",
        cap_bits[base], exp_frame(1'b1, 5'd0, 5'd0, 16'h0C00));
    if (n_exp > 1)
      chk(cap_bits[base+1] == exp_frame(1'b1, second_addr, 5'd0, 16'h0C00), "R3",
          cap_bits[base+1], exp_frame(1'b1, second_addr, 5'd0, 16'h0C00));
    chk(link_forced == 2'b00, "R9", link_forced, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_startup_full();
    t_read(5'd3, 5'd2, 16'hA5C3);
    t_write(5'h12, 5'h1B, 16'h1234);
    t_read(5'h1F, 5'h1F, 16'h8001);
    t_skip(8'hE4, 8'h05, 2, 5'd5);
    t_skip(8'hE0, 8'hFF, 1, 5'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule